// File: doc/BRIEF.md
# Diagnostic Threshold Flag Generator

This block watches three monitored quantities of an optical transceiver (internal temperature, supply voltage and receive modulation margin) and compares each fresh sample against stored limits. The comparison results are packed into four flag bytes. Two bytes carry the alarm level and two carry the warning level, and a diagnostics page exposes them to a host.

Each quantity arrives with its own valid strobe. Its flags are recomputed only on that strobe and hold their value between samples. Temperature and margin are two's-complement numbers and are compared as signed values. Voltage is an unsigned count and is compared as unsigned. Temperature and voltage each have a high limit and a low limit at both levels. Margin has only low limits.

The limits live inside the block and start from fixed reset values. A simple write port can replace any one limit per cycle. Converting raw readings into these units, and the host bus itself, are handled elsewhere.

Top module: `thresh_flags`

## Requirements
- R1: While reset is asserted, and after it until a quantity's first valid strobe, all four flag bytes read 0x00.
- R2: On `temp_valid`, temperature is compared as a signed 16-bit value. The high alarm and high warning flags are set when the value is strictly greater than the limit, and the low flags are set when it is strictly less. In `alarm_main` and `warn_main`, bit 7 is the high flag and bit 6 is the low flag. The result is visible one clock after the strobe edge.
- R3: On `volt_valid`, voltage is compared as an unsigned 16-bit value with the same strict rules. In `alarm_main` and `warn_main`, bit 5 is the high flag and bit 4 is the low flag.
- R4: On `marg_valid`, margin is compared as a signed 8-bit value against low limits only. The flag is bit 5 of `alarm_aux` (alarm) and bit 5 of `warn_aux` (warning), set when the value is strictly less than the limit.
- R5: Bits 3..0 of `alarm_main` and `warn_main` are always 0. Bits 7, 6 and 4..0 of `alarm_aux` and `warn_aux` are always 0.
- R6: A quantity's flags change only on that quantity's own strobe. Without the strobe, they hold their value regardless of input values or of other strobes.
- R7: When `lim_we` is high, `lim_wdata` is written into the limit selected by `lim_sel` at the clock edge. The selectors are: 0 temp high alarm, 1 temp low alarm, 2 temp high warning, 3 temp low warning, 4 volt high alarm, 5 volt low alarm, 6 volt high warning, 7 volt low warning, 8 margin low alarm (low byte), 9 margin low warning (low byte). Selectors 10..15 change nothing. A sample strobed in the same cycle as a write is compared against the old limit.
- R8: Reset loads these limits: temperature high/low alarm 0x7300/0xD800, high/low warning 0x6900/0xE700; voltage high/low alarm 0x9858/0x6978, high/low warning 0x8DCC/0x7404; margin low alarm 0x08, low warning 0x12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_valid | input | 1 | Temperature sample strobe |
| temp_value | input | 16 | Temperature, two's complement |
| volt_valid | input | 1 | Voltage sample strobe |
| volt_value | input | 16 | Supply voltage, unsigned |
| marg_valid | input | 1 | Margin sample strobe |
| marg_value | input | 8 | Receive margin, two's complement |
| lim_we | input | 1 | Limit write enable |
| lim_sel | input | 4 | Limit selector |
| lim_wdata | input | 16 | Limit write data |
| alarm_main | output | 8 | Temperature and voltage alarm flags |
| alarm_aux | output | 8 | Margin alarm flag |
| warn_main | output | 8 | Temperature and voltage warning flags |
| warn_aux | output | 8 | Margin warning flag |

## Verification
The hardest case to reach is a value exactly equal to a limit, or one that is only one count away. Random 16-bit samples almost never land there. The same holds for the sign boundary, where an unsigned comparator would give the opposite answer. Directed steps therefore place samples on, just above and just below every default limit, and use the most negative codes. A limit is rewritten in the same cycle as a sample to show that the old value is used. Random strobes on independent quantities, mixed with random limit writes, then exercise the holding behaviour across thousands of cycles.

// File: rtl/thresh_flags.sv
module thresh_flags #(
  parameter int TW = 16,
  parameter int VW = 16,
  parameter int MW = 8,
  parameter int DW = 16,
  parameter int SW = 4,
  parameter logic [TW-1:0] T_HA_RST = 16'h7300,
  parameter logic [TW-1:0] T_LA_RST = 16'hD800,
  parameter logic [TW-1:0] T_HW_RST = 16'h6900,
  parameter logic [TW-1:0] T_LW_RST = 16'hE700,
  parameter logic [VW-1:0] V_HA_RST = 16'h9858,
  parameter logic [VW-1:0] V_LA_RST = 16'h6978,
  parameter logic [VW-1:0] V_HW_RST = 16'h8DCC,
  parameter logic [VW-1:0] V_LW_RST = 16'h7404,
  parameter logic [MW-1:0] M_LA_RST = 8'h08,
  parameter logic [MW-1:0] M_LW_RST = 8'h12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          temp_valid,
  input  logic [TW-1:0] temp_value,
  input  logic          volt_valid,
  input  logic [VW-1:0] volt_value,
  input  logic          marg_valid,
  input  logic [MW-1:0] marg_value,
  input  logic          lim_we,
  input  logic [SW-1:0] lim_sel,
  input  logic [DW-1:0] lim_wdata,
  output logic [7:0]    alarm_main,
  output logic [7:0]    alarm_aux,
  output logic [7:0]    warn_main,
  output logic [7:0]    warn_aux
);

  logic [TW-1:0] t_ha, t_la, t_hw, t_lw;
  logic [VW-1:0] v_ha, v_la, v_hw, v_lw;
  logic [MW-1:0] m_la, m_lw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_ha <= T_HA_RST;  t_la <= T_LA_RST;
      t_hw <= T_HW_RST;  t_lw <= T_LW_RST;
      v_ha <= V_HA_RST;  v_la <= V_LA_RST;
      v_hw <= V_HW_RST;  v_lw <= V_LW_RST;
      m_la <= M_LA_RST;  m_lw <= M_LW_RST;
    end else if (lim_we) begin
      case (lim_sel)
        SW'(0): t_ha <= lim_wdata[TW-1:0];
        SW'(1): t_la <= lim_wdata[TW-1:0];
        SW'(2): t_hw <= lim_wdata[TW-1:0];
        SW'(3): t_lw <= lim_wdata[TW-1:0];
        SW'(4): v_ha <= lim_wdata[VW-1:0];
        SW'(5): v_la <= lim_wdata[VW-1:0];
        SW'(6): v_hw <= lim_wdata[VW-1:0];
        SW'(7): v_lw <= lim_wdata[VW-1:0];
        SW'(8): m_la <= lim_wdata[MW-1:0];
        SW'(9): m_lw <= lim_wdata[MW-1:0];
        default: ;
      endcase
    end
  end

  // {high alarm, low alarm, high warning, low warning}
  logic [3:0] t_flag, v_flag;
  // {low alarm, low warning}
  logic [1:0] m_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_flag <= '0;
      v_flag <= '0;
      m_flag <= '0;
    end else begin
      if (temp_valid)
        t_flag <= {$signed(temp_value) > $signed(t_ha), $signed(temp_value) < $signed(t_la),
                   $signed(temp_value) > $signed(t_hw), $signed(temp_value) < $signed(t_lw)};
      if (volt_valid)
        v_flag <= {volt_value > v_ha, volt_value < v_la,
                   volt_value > v_hw, volt_value < v_lw};
      if (marg_valid)
        m_flag <= {$signed(marg_value) < $signed(m_la), $signed(marg_value) < $signed(m_lw)};
    end
  end

  assign alarm_main = {t_flag[3], t_flag[2], v_flag[3], v_flag[2], 4'b0000};
  assign warn_main  = {t_flag[1], t_flag[0], v_flag[1], v_flag[0], 4'b0000};
  assign alarm_aux  = {2'b00, m_flag[1], 5'b00000};
  assign warn_aux   = {2'b00, m_flag[0], 5'b00000};

endmodule

// File: rtl/thresh_flags_chk.sv
module thresh_flags_chk #(
  parameter int TW = 16,
  parameter int VW = 16,
  parameter int MW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          temp_valid,
  input logic [TW-1:0] temp_value,
  input logic          volt_valid,
  input logic [VW-1:0] volt_value,
  input logic          marg_valid,
  input logic [MW-1:0] marg_value,
  input logic [TW-1:0] t_ha,
  input logic [TW-1:0] t_la,
  input logic [VW-1:0] v_ha,
  input logic [VW-1:0] v_la,
  input logic [MW-1:0] m_la,
  input logic [MW-1:0] m_lw,
  input logic [7:0]    alarm_main,
  input logic [7:0]    alarm_aux,
  input logic [7:0]    warn_main,
  input logic [7:0]    warn_aux
);

  always @(posedge clk)
    if (!rst_n)
      assert_reset_clear_R1: assert ((alarm_main | alarm_aux | warn_main | warn_aux) == 8'h00);

  assert_temp_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    temp_valid |=> alarm_main[7] == ($signed($past(temp_value)) > $signed($past(t_ha))));

  assert_temp_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    temp_valid |=> alarm_main[6] == ($signed($past(temp_value)) < $signed($past(t_la))));

  assert_volt_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    volt_valid |=> alarm_main[5] == ($past(volt_value) > $past(v_ha)));

  assert_volt_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    volt_valid |=> alarm_main[4] == ($past(volt_value) < $past(v_la)));

  assert_marg_alarm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    marg_valid |=> alarm_aux[5] == ($signed($past(marg_value)) < $signed($past(m_la))));

  assert_marg_warn_R4: assert property (@(posedge clk) disable iff (!rst_n)
    marg_valid |=> warn_aux[5] == ($signed($past(marg_value)) < $signed($past(m_lw))));

  assert_spare_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_main[3:0] == 4'h0) && (warn_main[3:0] == 4'h0) &&
    ((alarm_aux & 8'hDF) == 8'h00) && ((warn_aux & 8'hDF) == 8'h00));

  assert_temp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !temp_valid |=> $stable(alarm_main[7:6]) && $stable(warn_main[7:6]));

  assert_volt_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !volt_valid |=> $stable(alarm_main[5:4]) && $stable(warn_main[5:4]));

  assert_marg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !marg_valid |=> $stable(alarm_aux) && $stable(warn_aux));

endmodule

bind thresh_flags thresh_flags_chk #(.TW(TW), .VW(VW), .MW(MW)) chk (
  .clk(clk), .rst_n(rst_n),
  .temp_valid(temp_valid), .temp_value(temp_value),
  .volt_valid(volt_valid), .volt_value(volt_value),
  .marg_valid(marg_valid), .marg_value(marg_value),
  .t_ha(t_ha), .t_la(t_la), .v_ha(v_ha), .v_la(v_la),
  .m_la(m_la), .m_lw(m_lw),
  .alarm_main(alarm_main), .alarm_aux(alarm_aux),
  .warn_main(warn_main), .warn_aux(warn_aux)
);

// File: tb/thresh_flags_test.sv
module thresh_flags_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        temp_valid = 1'b0, volt_valid = 1'b0, marg_valid = 1'b0;
  logic [15:0] temp_value = '0, volt_value = '0;
  logic [7:0]  marg_value = '0;
  logic        lim_we = 1'b0;
  logic [3:0]  lim_sel = '0;
  logic [15:0] lim_wdata = '0;
  logic [7:0]  alarm_main, alarm_aux, warn_main, warn_aux;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  thresh_flags uut (
    .clk(clk), .rst_n(rst_n),
    .temp_valid(temp_valid), .temp_value(temp_value),
    .volt_valid(volt_valid), .volt_value(volt_value),
    .marg_valid(marg_valid), .marg_value(marg_value),
    .lim_we(lim_we), .lim_sel(lim_sel), .lim_wdata(lim_wdata),
    .alarm_main(alarm_main), .alarm_aux(alarm_aux),
    .warn_main(warn_main), .warn_aux(warn_aux)
  );

  // bench model: limits in selector order and expected flag bits
  logic [15:0] bl [10];
  logic [3:0]  et, ev;
  logic [1:0]  em;

  function automatic logic [15:0] default_limit(int i);
    case (i)
      0: return 16'h7300; 1: return 16'hD800; 2: return 16'h6900; 3: return 16'hE700;
      4: return 16'h9858; 5: return 16'h6978; 6: return 16'h8DCC; 7: return 16'h7404;
      8: return 16'h0008; default: return 16'h0012;
    endcase
  endfunction

  function automatic logic [31:0] expected_bytes();
    return {et[3], et[2], ev[3], ev[2], 4'h0,
            2'b00, em[1], 5'h00,
            et[1], et[0], ev[1], ev[0], 4'h0,
            2'b00, em[0], 5'h00};
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 10; i++) bl[i] = default_limit(i);
    et = '0; ev = '0; em = '0;
  endtask

  task automatic compare(string tag);
    logic [31:0] got, exp;
    got = {alarm_main, alarm_aux, warn_main, warn_aux};
    exp = expected_bytes();
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: flags actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic step(string tag, bit tv, logic [15:0] t, bit vv, logic [15:0] v,
                      bit mv, logic [7:0] m, bit we, logic [3:0] sel, logic [15:0] wd);
    @(negedge clk);
    temp_valid = tv; temp_value = t;
    volt_valid = vv; volt_value = v;
    marg_valid = mv; marg_value = m;
    lim_we = we; lim_sel = sel; lim_wdata = wd;
    @(negedge clk);
    temp_valid = 1'b0; volt_valid = 1'b0; marg_valid = 1'b0; lim_we = 1'b0;
    if (tv) et = {$signed(t) > $signed(bl[0]), $signed(t) < $signed(bl[1]),
                  $signed(t) > $signed(bl[2]), $signed(t) < $signed(bl[3])};
    if (vv) ev = {v > bl[4], v < bl[5], v > bl[6], v < bl[7]};
    if (mv) em = {$signed(m) < $signed(bl[8][7:0]), $signed(m) < $signed(bl[9][7:0])};
    if (we && sel < 4'd10) bl[sel] = wd;
    compare(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    compare("R1 in reset");
    rst_n = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd5150));
    model_reset();
    repeat (3) @(negedge clk);
    compare("R1 reset state");
    rst_n = 1'b1;
    // no strobe yet, extreme values on the inputs
    step("R1 no strobe yet", 0, 16'h8000, 0, 16'hFFFF, 0, 8'h80, 0, 0, 0);

    // temperature, default limits (R8) and signed strictness (R2)
    step("R2 R8 temp equal high alarm", 1, 16'h7300, 0, 0, 0, 0, 0, 0, 0);
    step("R2 R8 temp above high alarm", 1, 16'h7301, 0, 0, 0, 0, 0, 0, 0);
    step("R2 R8 temp equal high warn",  1, 16'h6900, 0, 0, 0, 0, 0, 0, 0);
    step("R2 R8 temp equal low alarm",  1, 16'hD800, 0, 0, 0, 0, 0, 0, 0);
    step("R2 R8 temp below low alarm",  1, 16'hD7FF, 0, 0, 0, 0, 0, 0, 0);
    step("R2 R8 temp equal low warn",   1, 16'hE700, 0, 0, 0, 0, 0, 0, 0);
    step("R2 temp most negative",       1, 16'h8000, 0, 0, 0, 0, 0, 0, 0);
    step("R2 temp most positive",       1, 16'h7FFF, 0, 0, 0, 0, 0, 0, 0);
    step("R2 temp zero",                1, 16'h0000, 0, 0, 0, 0, 0, 0, 0);

    // voltage unsigned (R3)
    step("R3 R8 volt max code",         0, 0, 1, 16'hFFFF, 0, 0, 0, 0, 0);
    step("R3 R8 volt equal high alarm", 0, 0, 1, 16'h9858, 0, 0, 0, 0, 0);
    step("R3 R8 volt above high alarm", 0, 0, 1, 16'h9859, 0, 0, 0, 0, 0);
    step("R3 R8 volt equal high warn",  0, 0, 1, 16'h8DCC, 0, 0, 0, 0, 0);
    step("R3 R8 volt equal low alarm",  0, 0, 1, 16'h6978, 0, 0, 0, 0, 0);
    step("R3 R8 volt below low alarm",  0, 0, 1, 16'h6977, 0, 0, 0, 0, 0);
    step("R3 R8 volt equal low warn",   0, 0, 1, 16'h7404, 0, 0, 0, 0, 0);
    step("R3 volt zero",                0, 0, 1, 16'h0000, 0, 0, 0, 0, 0);

    // margin signed low only (R4)
    step("R4 R8 margin most negative",  0, 0, 0, 0, 1, 8'h80, 0, 0, 0);
    step("R4 R8 margin equal alarm",    0, 0, 0, 0, 1, 8'h08, 0, 0, 0);
    step("R4 R8 margin below alarm",    0, 0, 0, 0, 1, 8'h07, 0, 0, 0);
    step("R4 R8 margin equal warn",     0, 0, 0, 0, 1, 8'h12, 0, 0, 0);
    step("R4 margin most positive",     0, 0, 0, 0, 1, 8'h7F, 0, 0, 0);

    // hold (R6): temp low flags set, volt flags set, then only other strobes
    step("R6 set temp low",             1, 16'h8000, 1, 16'hFFFF, 1, 8'h80, 0, 0, 0);
    step("R6 temp holds on volt strobe",0, 16'h7FFF, 1, 16'h0000, 0, 8'h7F, 0, 0, 0);
    step("R6 volt holds on temp strobe",1, 16'h7FFF, 0, 16'hFFFF, 0, 8'h7F, 0, 0, 0);
    step("R6 all hold without strobe",  0, 16'h0000, 0, 16'h7000, 0, 8'h10, 0, 0, 0);

    // limit writes (R7)
    step("R7 write same cycle uses old",1, 16'h0010, 0, 0, 0, 0, 1, 4'd0, 16'h0000);
    step("R7 new temp limit applies",   1, 16'h0010, 0, 0, 0, 0, 0, 0, 0);
    step("R7 write margin warn limit",  0, 0, 0, 0, 0, 0, 1, 4'd9, 16'hFF80);
    step("R7 margin new limit",         0, 0, 0, 0, 1, 8'h81, 0, 0, 0);
    step("R7 unused selector",          0, 0, 0, 0, 0, 0, 1, 4'd12, 16'h0000);
    step("R7 unused selector no effect",1, 16'h7301, 1, 16'h9859, 1, 8'h07, 0, 0, 0);

    // R1 and R8 after a second reset
    do_reset();
    step("R1 R8 defaults restored",     1, 16'h0010, 0, 0, 0, 0, 0, 0, 0);

    // random mix (R2 R3 R4 R5 R6 R7)
    for (int n = 0; n < 3000; n++) begin
      bit tv, vv, mv, we;
      logic [15:0] t, v, wd;
      logic [7:0] m;
      logic [3:0] sel;
      tv = ($urandom % 3) == 0;
      vv = ($urandom % 3) == 0;
      mv = ($urandom % 3) == 0;
      we = ($urandom % 10) == 0;
      sel = 4'($urandom);
      wd = 16'($urandom);
      t = ($urandom % 4 == 0) ? bl[$urandom % 4] + 16'($signed($urandom % 3) - 1) : 16'($urandom);
      v = ($urandom % 4 == 0) ? bl[4 + $urandom % 4] + 16'($signed($urandom % 3) - 1) : 16'($urandom);
      m = ($urandom % 4 == 0) ? bl[8 + $urandom % 2][7:0] + 8'($signed($urandom % 3) - 1) : 8'($urandom);
      step("R2 R3 R4 R5 R6 R7 random", tv, t, vv, v, mv, m, we, sel, wd);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule